// File: doc/BRIEF.md
# Gated Single-Pulse Width Timer

This block measures how long one pulse on an asynchronous gate input stays at its active level. Software picks the gate polarity and a power-of-two prescale, and clears the count. It then raises an arm request. The armed block waits for a fresh leading edge on the synchronized gate. While the gate stays active, the block adds one to a 16-bit counter for every prescaled tick. On the trailing edge the block stops, disarms itself and raises a sticky completion flag.

A wrap of the 16-bit counter raises a sticky overflow flag. The same wrap bumps an 8-bit overflow counter that is cleared with the main count. Software can therefore form a 24-bit width as overflows times 65536 plus the final count. A single interrupt line combines both flags with their individual enables. One measurement is taken per arm. Later pulses are ignored until software arms the block again.

Top module: `gate_pulse_timer`

## Requirements
- R1: After reset, `count` and `ovf_count` are 0, and `armed`, `done_flag`, `ovf_flag` and `irq` are 0.
- R2: The gate input passes through a two-flop synchronizer. Once armed, the counter adds 1 for each prescaled tick during which the synchronized gate is active. With prescale select 0, a pulse held for N clock cycles adds exactly N.
- R3: Prescale select s (0..7) gives one tick every 2^s window cycles. The tick phase restarts at each leading edge, so a pulse of N cycles adds floor(N / 2^s).
- R4: `cfg_active_low` = 0 measures high pulses and `cfg_active_low` = 1 measures low pulses.
- R5: If the gate is already active when the block is armed, nothing is counted and no completion is raised until the gate goes inactive and a new leading edge arrives.
- R6: The trailing edge of the measured pulse sets `done_flag` and clears `armed`. Further pulses leave `count` unchanged until the next arm.
- R7: An arm request is ignored while `cfg_enable` is 0. Dropping `cfg_enable` while armed disarms the block.
- R8: `clr_count` sets both `count` and `ovf_count` to 0 at the next clock edge, and it takes priority over an increment.
- R9: An increment from 65535 gives 0, sets `ovf_flag` and adds 1 to `ovf_count`.
- R10: `done_flag` and `ovf_flag` stay set until their clear inputs are raised. A flag set in the same cycle as its clear wins, and the flag stays 1.
- R11: `irq` is 1 exactly when (`done_flag` and `irq_en_done`) or (`ovf_flag` and `irq_en_ovf`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Block enable; low disarms |
| cfg_active_low | input | 1 | Gate polarity: 0 active-high, 1 active-low |
| cfg_prescale | input | 3 | Tick divide select, ratio 2^value |
| irq_en_done | input | 1 | Interrupt enable for completion flag |
| irq_en_ovf | input | 1 | Interrupt enable for overflow flag |
| arm_req | input | 1 | One-cycle request to arm a measurement |
| clr_count | input | 1 | Clear count and overflow count |
| clr_done | input | 1 | Clear completion flag |
| clr_ovf | input | 1 | Clear overflow flag |
| gate_in | input | 1 | Asynchronous gate signal |
| count | output | 16 | Measured tick count |
| ovf_count | output | 8 | Number of count wraps since last clear |
| armed | output | 1 | Measurement armed or in progress |
| done_flag | output | 1 | Sticky completion flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Combined interrupt |

## Verification
The completion flag can be set by a trailing edge and cleared by software in the same cycle. The bench provokes this by timing `clr_done` to the edge at which the synchronized fall is registered, two cycles after the gate drops. It judges the result by requiring `done_flag` to read 1 afterwards, then checks that a plain clear still works. Count clear and increment can also coincide, and the counter assertions judge that case. Randomized pulse widths, polarities and prescale settings are compared against floor(N / 2^s) accumulated by bench functions.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_LEAD = 2'd1,
    ST_COUNT     = 2'd2
  } gpt_state_e;

  // Terminal phase value of the prescaler for a divide by 2^sel.
  function automatic int unsigned div_mask(input int unsigned sel);
    return (32'd1 << sel) - 32'd1;
  endfunction

  // Ticks delivered by a window of n cycles at divide 2^sel.
  function automatic int unsigned ticks_in_window(input int unsigned n,
                                                  input int unsigned sel);
    return n >> sel;
  endfunction

endpackage

// File: rtl/gpt_gate_sync.sv
module gpt_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  input  logic active_low,
  output logic gate_act,
  output logic gate_rise,
  output logic gate_fall
);

  logic [STAGES-1:0] sync_q;
  logic              act_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= gate_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], gate_in};
      end
    end
  endgenerate

  // polarity applied after the synchronizer
  assign gate_act = sync_q[STAGES-1] ^ active_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= gate_act;
  end

  assign gate_rise = gate_act & ~act_q;
  assign gate_fall = ~gate_act & act_q;

  // R2
  rise_not_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> !gate_rise);

  // R2
  rise_fall_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_rise && gate_fall));

endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import gpt_pkg::*;

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] mask;

  assign mask = DIV_W'(div_mask(32'(sel)));
  assign tick = run && (phase_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (!run)  phase_q <= '0;
    else if (tick)  phase_q <= '0;
    else            phase_q <= phase_q + 1'b1;
  end

  // R3
  phase_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= mask || $changed(sel));

endmodule

// File: rtl/gpt_ctrl.sv
module gpt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic arm_req,
  input  logic gate_act,
  input  logic gate_rise,
  input  logic gate_fall,
  input  logic clr_done,
  input  logic clr_ovf,
  input  logic wrap_evt,
  output logic window,
  output logic armed,
  output logic done_flag,
  output logic ovf_flag,
  output logic done_evt
);
  import gpt_pkg::*;

  gpt_state_e state_q, state_d;
  logic       done_q, ovf_q;

  always_comb begin
    state_d  = state_q;
    done_evt = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:      if (arm_req)   state_d = ST_WAIT_LEAD;
        ST_WAIT_LEAD: if (gate_rise) state_d = ST_COUNT;
        ST_COUNT: begin
          if (gate_fall) begin
            state_d  = ST_IDLE;
            done_evt = 1'b1;
          end
        end
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // counting window: the leading-edge cycle plus every active cycle after it
  assign window = enable &&
                  (((state_q == ST_WAIT_LEAD) && gate_rise) ||
                   ((state_q == ST_COUNT) && gate_act));

  assign armed = (state_q != ST_IDLE);

  // sticky flags, a set beats a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (done_evt)      done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
      if (wrap_evt)      ovf_q  <= 1'b1;
      else if (clr_ovf)  ovf_q  <= 1'b0;
    end
  end

  assign done_flag = done_q;
  assign ovf_flag  = ovf_q;

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (done_flag && !armed));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !clr_done) |=> done_flag);

  // R10
  ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);

  // R7
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !armed);

  // R5
  no_window_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window |-> armed);

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic [OVF_W-1:0] ovf_count,
  output logic             wrap_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [OVF_W-1:0] ovf_q;

  assign wrap_evt = inc && !clr && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      ovf_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap_evt) ovf_q <= ovf_q + 1'b1;
    end
  end

  assign count     = cnt_q;
  assign ovf_count = ovf_q;

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && ovf_count == '0));

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> ($stable(count) && $stable(ovf_count)));

  // R9
  ovf_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count == '0 && ovf_count == OVF_W'($past(ovf_count) + 1'b1)));

endmodule

// File: rtl/gate_pulse_timer.sv
module gate_pulse_timer #(
  parameter int CNT_W       = 16,
  parameter int OVF_W       = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_active_low,
  input  logic [SEL_W-1:0] cfg_prescale,
  input  logic             irq_en_done,
  input  logic             irq_en_ovf,
  input  logic             arm_req,
  input  logic             clr_count,
  input  logic             clr_done,
  input  logic             clr_ovf,
  input  logic             gate_in,
  output logic [CNT_W-1:0] count,
  output logic [OVF_W-1:0] ovf_count,
  output logic             armed,
  output logic             done_flag,
  output logic             ovf_flag,
  output logic             irq
);

  logic gate_act, gate_rise, gate_fall;
  logic window, tick, inc, wrap_evt, done_evt;

  gpt_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_in    (gate_in),
    .active_low (cfg_active_low),
    .gate_act   (gate_act),
    .gate_rise  (gate_rise),
    .gate_fall  (gate_fall)
  );

  gpt_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (window),
    .sel   (cfg_prescale),
    .tick  (tick)
  );

  gpt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_enable),
    .arm_req   (arm_req),
    .gate_act  (gate_act),
    .gate_rise (gate_rise),
    .gate_fall (gate_fall),
    .clr_done  (clr_done),
    .clr_ovf   (clr_ovf),
    .wrap_evt  (wrap_evt),
    .window    (window),
    .armed     (armed),
    .done_flag (done_flag),
    .ovf_flag  (ovf_flag),
    .done_evt  (done_evt)
  );

  assign inc = window && tick;

  gpt_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_count),
    .inc       (inc),
    .count     (count),
    .ovf_count (ovf_count),
    .wrap_evt  (wrap_evt)
  );

  assign irq = (done_flag & irq_en_done) | (ovf_flag & irq_en_ovf);

  // R6
  no_count_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> !inc);

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_flag || ovf_flag));

endmodule

// File: tb/gate_pulse_timer_tb.sv
module gate_pulse_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_active_low = 1'b0;
  logic [2:0]  cfg_prescale = 3'd0;
  logic        irq_en_done = 1'b0;
  logic        irq_en_ovf = 1'b0;
  logic        arm_req = 1'b0;
  logic        clr_count = 1'b0;
  logic        clr_done = 1'b0;
  logic        clr_ovf = 1'b0;
  logic        gate_in = 1'b0;
  logic [15:0] count;
  logic [7:0]  ovf_count;
  logic        armed, done_flag, ovf_flag, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gate_pulse_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_active_low(cfg_active_low), .cfg_prescale(cfg_prescale),
    .irq_en_done(irq_en_done), .irq_en_ovf(irq_en_ovf),
    .arm_req(arm_req), .clr_count(clr_count), .clr_done(clr_done),
    .clr_ovf(clr_ovf), .gate_in(gate_in), .count(count),
    .ovf_count(ovf_count), .armed(armed), .done_flag(done_flag),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  function automatic int unsigned exp_ticks(input int unsigned n, input int unsigned s);
    int unsigned d = 1;
    for (int k = 0; k < int'(s); k++) d = d * 2;
    return n / d;
  endfunction

  function automatic logic exp_irq(input logic d, input logic o, input logic ed, input logic eo);
    if (d && ed) return 1'b1;
    if (o && eo) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_one(input string sig, output logic v);
    v = 1'b1;
    @(negedge clk);
    v = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm_req = 1'b1;
    @(negedge clk); arm_req = 1'b0;
  endtask

  task automatic do_clr_count();
    @(negedge clk); clr_count = 1'b1;
    @(negedge clk); clr_count = 1'b0;
  endtask

  task automatic do_clr_done();
    @(negedge clk); clr_done = 1'b1;
    @(negedge clk); clr_done = 1'b0;
  endtask

  task automatic set_idle(input logic pol);
    @(negedge clk);
    cfg_active_low = pol;
    gate_in = pol;
    cycles(5);
  endtask

  // gate active for n clock cycles, then back to idle
  task automatic gate_pulse(input int n);
    @(negedge clk);
    gate_in = ~cfg_active_low;
    cycles(n);
    gate_in = cfg_active_low;
  endtask

  task automatic measure(input int n);
    do_arm();
    cycles(2);
    gate_pulse(n);
    cycles(6);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int unsigned exp_cnt;
    void'($urandom(32'd20240611));
    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R1 reset state
    check("R1", "count", 32'(count), 0);
    check("R1", "ovf_count", 32'(ovf_count), 0);
    check("R1", "armed", 32'(armed), 0);
    check("R1", "done_flag", 32'(done_flag), 0);
    check("R1", "ovf_flag", 32'(ovf_flag), 0);
    check("R1", "irq", 32'(irq), 0);

    cfg_enable = 1'b1;
    set_idle(1'b0);

    // R2 basic width at 1:1
    measure(10);
    check("R2", "count after 10-cycle pulse", 32'(count), 10);
    check("R6", "done after trailing edge", 32'(done_flag), 1);
    check("R6", "armed cleared", 32'(armed), 0);

    // R6 pulse without re-arm is ignored
    do_clr_done();
    gate_pulse(7);
    cycles(6);
    check("R6", "count unchanged without arm", 32'(count), 10);
    check("R6", "done stays clear", 32'(done_flag), 0);

    // R8 clear
    do_clr_count();
    check("R8", "count cleared", 32'(count), 0);

    // R4 active-low pulse
    set_idle(1'b1);
    measure(13);
    check("R4", "active-low count", 32'(count), 13);
    check("R4", "active-low done", 32'(done_flag), 1);
    do_clr_done();
    set_idle(1'b0);

    // R3 prescale
    do_clr_count();
    cfg_prescale = 3'd2;
    measure(23);
    check("R3", "div4 of 23", 32'(count), exp_ticks(23, 2));
    do_clr_done();
    cfg_prescale = 3'd3;
    measure(16);
    check("R3", "div8 of 16 accumulated", 32'(count), exp_ticks(23, 2) + exp_ticks(16, 3));
    do_clr_done();
    cfg_prescale = 3'd0;

    // R5 armed while gate already active
    do_clr_count();
    @(negedge clk); gate_in = 1'b1;
    cycles(5);
    do_arm();
    cycles(10);
    check("R5", "no count while pre-active", 32'(count), 0);
    check("R5", "still armed", 32'(armed), 1);
    @(negedge clk); gate_in = 1'b0;
    cycles(6);
    check("R5", "no done on stale fall", 32'(done_flag), 0);
    check("R5", "armed after stale fall", 32'(armed), 1);
    gate_pulse(9);
    cycles(6);
    check("R5", "fresh pulse counted", 32'(count), 9);
    check("R5", "done after fresh pulse", 32'(done_flag), 1);

    // R11 interrupt gating
    irq_en_done = 1'b0;
    cycles(1);
    check("R11", "irq masked", 32'(irq), 32'(exp_irq(done_flag, ovf_flag, 1'b0, 1'b0)));
    irq_en_done = 1'b1;
    cycles(1);
    check("R11", "irq from done", 32'(irq), 1);
    do_clr_done();
    check("R11", "irq after clear", 32'(irq), 0);

    // R7 enable gating
    cfg_enable = 1'b0;
    do_arm();
    cycles(1);
    check("R7", "arm ignored when disabled", 32'(armed), 0);
    cfg_enable = 1'b1;
    do_arm();
    check("R7", "arm accepted when enabled", 32'(armed), 1);
    @(negedge clk); cfg_enable = 1'b0;
    cycles(2);
    check("R7", "disable disarms", 32'(armed), 0);
    cfg_enable = 1'b1;
    cycles(3);

    // R10 set and clear of done in the same cycle: set wins
    do_clr_count();
    do_arm();
    cycles(2);
    @(negedge clk); gate_in = 1'b1;
    cycles(5);
    gate_in = 1'b0;                 // drop at negedge n0
    cycles(2);                      // now at n0+2
    clr_done = 1'b1;
    cycles(1);                      // n0+3
    clr_done = 1'b0;
    check("R10", "done set wins over clear", 32'(done_flag), 1);
    check("R10", "collision pulse count", 32'(count), 5);
    cycles(3);
    check("R10", "done sticky", 32'(done_flag), 1);
    do_clr_done();
    check("R10", "done clears", 32'(done_flag), 0);

    // R9 overflow past 16 bits
    do_clr_count();
    irq_en_ovf = 1'b1;
    irq_en_done = 1'b0;
    measure(65536 + 7);
    check("R9", "count after wrap", 32'(count), 7);
    check("R9", "ovf_count", 32'(ovf_count), 1);
    check("R9", "ovf_flag", 32'(ovf_flag), 1);
    check("R11", "irq from overflow", 32'(irq), 1);
    @(negedge clk); clr_ovf = 1'b1;
    @(negedge clk); clr_ovf = 1'b0;
    check("R10", "ovf clears", 32'(ovf_flag), 0);
    check("R8", "ovf_count kept until count clear", 32'(ovf_count), 1);
    do_clr_count();
    check("R8", "ovf_count cleared", 32'(ovf_count), 0);
    do_clr_done();
    irq_en_ovf = 1'b0;

    // random widths, polarities and prescale
    exp_cnt = 0;
    for (int i = 0; i < 24; i++) begin
      int unsigned sel = $urandom % 4;
      int unsigned pol = $urandom % 2;
      int unsigned wid = 1 + ($urandom % 50);
      if (($urandom % 3) == 0) begin
        do_clr_count();
        exp_cnt = 0;
      end
      set_idle(pol[0]);
      cfg_prescale = sel[2:0];
      measure(int'(wid));
      exp_cnt = (exp_cnt + exp_ticks(wid, sel)) & 32'hFFFF;
      check("R3", "random count", 32'(count), exp_cnt);
      check("R6", "random done", 32'(done_flag), 1);
      do_clr_done();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule